// File: doc/BRIEF.md
# Golden/Update Boot Image Selector

This controller decides which of two configuration images a card boots: the protected golden image (slot 0) or a field update (slot 1). When its prerequisites are reported ready, it captures the stored metadata flags (update pending, update committed) and picks a slot. It then supervises the attempt through its milestones: a reconfigure request, an integrity verdict, a load window bounded by a programmable done timeout, an optional health gate, and finally the run state. Link training is enabled only in the run state.

An update becomes permanent in two phases. A freshly written image is only *pending*. It is committed only after it passes both the integrity gate and the health gate. An integrity failure on the update rolls back to golden at once. Timeouts, health failures and training failures are retried up to a bounded number of attempts before rollback. Every rollback clears both update flags, increments a counter, and latches a reason code. Every failure latches the phase in which progress stopped.

The block never aims a write at the golden slot. If golden itself fails its integrity check, the block parks in a recovery state that requests service mode and issues no further reconfiguration.

Top module: `boot_image_selector`

## Requirements
- R1: After reset, the outputs are as follows: phase is 0 (wait), slot_sel is 0, reconfig_req, train_en and service_mode are 0, rollback_cnt is 0, rollback_why is 0, and stop_phase is 0.
- R2: In the wait phase, prereq_ok captures meta_pending and meta_commit. Each attempt raises reconfig_req for exactly one cycle, in phase 1 (select). slot_sel is 1 when an update flag is held and 0 otherwise.
- R3: The load phase (3) is entered only from the read phase (2) after integ_valid with integ_ok. An integrity failure while the update is selected causes an immediate rollback with reason code 1.
- R4: The load phase lasts at most tmo_limit+1 cycles (tmo_limit ≥ 1). A cfg_done in the last of those cycles still completes the load, because done has priority over the timeout.
- R5: A pending update goes from load to the health phase (4). A health pass sets commit_o, clears pending_o and enters run (5). Golden and committed images go straight from load to run. train_en is 1 only in run.
- R6: On the update slot, a timeout (reason 2), a health failure (reason 3) or a train_fail pulse in run (reason 4) triggers a retry of the update. The retry does not count as a rollback. The third such failure (MAX_TRIES = 3) causes a rollback.
- R7: A rollback selects golden, clears pending_o and commit_o, increments rollback_cnt and latches the reason. Every failure latches stop_phase, the phase code in which it happened.
- R8: A golden integrity failure enters recovery (phase 6). In recovery, service_mode is 1 and the block issues no further reconfig_req until reset.
- R9: A golden timeout or training failure retries golden. rollback_cnt and rollback_why do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prereq_ok | input | 1 | Power and clock prerequisites are stable |
| meta_pending | input | 1 | Stored flag: an update image awaits validation |
| meta_commit | input | 1 | Stored flag: the update image is committed |
| tmo_limit | input | TMO_W | Done-timeout limit in cycles |
| integ_valid | input | 1 | Integrity verdict strobe |
| integ_ok | input | 1 | Integrity verdict: pass |
| cfg_done | input | 1 | Configuration completed |
| health_valid | input | 1 | Health verdict strobe |
| health_ok | input | 1 | Health verdict: pass |
| train_fail | input | 1 | Initialisation or training failure while running |
| slot_sel | output | 1 | Selected slot: 0 golden, 1 update |
| reconfig_req | output | 1 | One-cycle request to load the selected slot |
| train_en | output | 1 | Downstream link training allowed |
| service_mode | output | 1 | Recovery: service access needed |
| phase | output | 3 | Current milestone code |
| pending_o | output | 1 | Updated pending flag to write back |
| commit_o | output | 1 | Updated commit flag to write back |
| rollback_cnt | output | CNT_W | Saturating rollback count |
| rollback_why | output | 3 | Reason code of the last rollback |
| stop_phase | output | 3 | Phase code of the last failure |

## Verification
The assertions assume the following about the inputs:
- Verdict strobes (integ_valid, health_valid) and train_fail arrive only in the phase that waits for them.
- tmo_limit is at least 1 and is held steady during a load window.
- cfg_done is not raised outside load.

The stimulus meets these assumptions by driving each verdict in the cycle after observing the matching phase code, for a single cycle. It then returns the signal to zero. Expected slot choices are queued per scenario from the retry and rollback rules and compared at every reconfigure request. A request that arrives with nothing expected counts as a failure.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  typedef enum logic [2:0] {
    PH_WAIT = 3'd0, PH_SELECT = 3'd1, PH_READ = 3'd2, PH_LOAD = 3'd3,
    PH_HEALTH = 3'd4, PH_RUN = 3'd5, PH_RECOVER = 3'd6
  } phase_e;

  typedef enum logic [2:0] {
    WHY_NONE = 3'd0, WHY_INTEG = 3'd1, WHY_TMO = 3'd2,
    WHY_HEALTH = 3'd3, WHY_TRAIN = 3'd4
  } why_e;

  typedef enum logic [1:0] {ACT_RETRY = 2'd0, ACT_ROLLBACK = 2'd1, ACT_RECOVER = 2'd2} act_e;

  // Decide the response to a failed attempt.
  function automatic act_e fail_action(input logic on_update, input why_e why,
                                       input int unsigned tries_after,
                                       input int unsigned max_tries);
    if (!on_update)
      return (why == WHY_INTEG) ? ACT_RECOVER : ACT_RETRY;
    if (why == WHY_INTEG || tries_after >= max_tries)
      return ACT_ROLLBACK;
    return ACT_RETRY;
  endfunction
endpackage

// File: rtl/bsel_timer.sv
module bsel_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (run)  count <= count + 1'b1;
    else           count <= '0;
  end

  assign expired = run && (count == limit);
endmodule

// File: rtl/bsel_ledger.sv
module bsel_ledger
  import bsel_pkg::*;
#(
  parameter int unsigned MAX_TRIES = 3,
  parameter int          CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             meta_pending,
  input  logic             meta_commit,
  input  logic             ev_commit,
  input  logic             ev_fail,
  input  why_e             fail_why,
  input  phase_e           fail_phase,
  output logic             cur_slot,
  output logic             pend,
  output logic             comm,
  output logic             need_health,
  output act_e             act,
  output logic [CNT_W-1:0] rb_cnt,
  output why_e             rb_why,
  output phase_e           stop_ph
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  logic [TRY_W-1:0] tries;

  assign act         = fail_action(cur_slot, fail_why, 32'(tries) + 32'd1, MAX_TRIES);
  assign need_health = cur_slot && pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_slot <= 1'b0;
      pend     <= 1'b0;
      comm     <= 1'b0;
      tries    <= '0;
      rb_cnt   <= '0;
      rb_why   <= WHY_NONE;
      stop_ph  <= PH_WAIT;
    end else if (capture) begin
      pend     <= meta_pending;
      comm     <= meta_commit;
      cur_slot <= meta_pending | meta_commit;
      tries    <= '0;
    end else if (ev_commit) begin
      comm <= 1'b1;
      pend <= 1'b0;
    end else if (ev_fail) begin
      stop_ph <= fail_phase;
      case (act)
        ACT_RETRY: if (cur_slot) tries <= tries + 1'b1;
        ACT_ROLLBACK: begin
          cur_slot <= 1'b0;
          pend     <= 1'b0;
          comm     <= 1'b0;
          tries    <= '0;
          rb_why   <= fail_why;
          if (rb_cnt != '1) rb_cnt <= rb_cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bsel_fsm.sv
module bsel_fsm
  import bsel_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   prereq_ok,
  input  logic   integ_valid,
  input  logic   integ_ok,
  input  logic   cfg_done,
  input  logic   tmo_expired,
  input  logic   health_valid,
  input  logic   health_ok,
  input  logic   train_fail,
  input  logic   need_health,
  input  act_e   act,
  output phase_e st,
  output logic   capture,
  output logic   ev_commit,
  output logic   ev_fail,
  output why_e   fail_why
);
  phase_e nxt;

  always_comb begin
    nxt       = st;
    capture   = 1'b0;
    ev_commit = 1'b0;
    ev_fail   = 1'b0;
    fail_why  = WHY_NONE;
    case (st)
      PH_WAIT:   if (prereq_ok) begin capture = 1'b1; nxt = PH_SELECT; end
      PH_SELECT: nxt = PH_READ;
      PH_READ:
        if (integ_valid) begin
          if (integ_ok) nxt = PH_LOAD;
          else begin ev_fail = 1'b1; fail_why = WHY_INTEG; end
        end
      PH_LOAD:
        if (cfg_done) nxt = need_health ? PH_HEALTH : PH_RUN;
        else if (tmo_expired) begin ev_fail = 1'b1; fail_why = WHY_TMO; end
      PH_HEALTH:
        if (health_valid) begin
          if (health_ok) begin ev_commit = 1'b1; nxt = PH_RUN; end
          else begin ev_fail = 1'b1; fail_why = WHY_HEALTH; end
        end
      PH_RUN:    if (train_fail) begin ev_fail = 1'b1; fail_why = WHY_TRAIN; end
      default:   nxt = st;
    endcase
    if (ev_fail) nxt = (act == ACT_RECOVER) ? PH_RECOVER : PH_SELECT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= PH_WAIT;
    else        st <= nxt;
  end
endmodule

// File: rtl/boot_image_selector.sv
module boot_image_selector
  import bsel_pkg::*;
#(
  parameter int unsigned MAX_TRIES = 3,
  parameter int          TMO_W     = 16,
  parameter int          CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prereq_ok,
  input  logic             meta_pending,
  input  logic             meta_commit,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             integ_valid,
  input  logic             integ_ok,
  input  logic             cfg_done,
  input  logic             health_valid,
  input  logic             health_ok,
  input  logic             train_fail,
  output logic             slot_sel,
  output logic             reconfig_req,
  output logic             train_en,
  output logic             service_mode,
  output logic [2:0]       phase,
  output logic             pending_o,
  output logic             commit_o,
  output logic [CNT_W-1:0] rollback_cnt,
  output logic [2:0]       rollback_why,
  output logic [2:0]       stop_phase
);
  phase_e st, stop_ph;
  why_e   fail_why, rb_why;
  act_e   act;
  logic   capture, ev_commit, ev_fail, tmo_expired, need_health;

  bsel_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st == PH_LOAD), .limit(tmo_limit),
    .expired(tmo_expired)
  );

  bsel_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .prereq_ok(prereq_ok), .integ_valid(integ_valid),
    .integ_ok(integ_ok), .cfg_done(cfg_done), .tmo_expired(tmo_expired),
    .health_valid(health_valid), .health_ok(health_ok), .train_fail(train_fail),
    .need_health(need_health), .act(act), .st(st), .capture(capture),
    .ev_commit(ev_commit), .ev_fail(ev_fail), .fail_why(fail_why)
  );

  bsel_ledger #(.MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W)) u_ledger (
    .clk(clk), .rst_n(rst_n), .capture(capture), .meta_pending(meta_pending),
    .meta_commit(meta_commit), .ev_commit(ev_commit), .ev_fail(ev_fail),
    .fail_why(fail_why), .fail_phase(st), .cur_slot(slot_sel), .pend(pending_o),
    .comm(commit_o), .need_health(need_health), .act(act), .rb_cnt(rollback_cnt),
    .rb_why(rb_why), .stop_ph(stop_ph)
  );

  assign phase        = st;
  assign reconfig_req = (st == PH_SELECT);
  assign train_en     = (st == PH_RUN);
  assign service_mode = (st == PH_RECOVER);
  assign rollback_why = rb_why;
  assign stop_phase   = stop_ph;
endmodule

// File: rtl/bsel_checker.sv
module bsel_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             integ_valid,
  input logic             integ_ok,
  input logic             cfg_done,
  input logic             health_valid,
  input logic             health_ok,
  input logic             slot_sel,
  input logic             reconfig_req,
  input logic             train_en,
  input logic             service_mode,
  input logic [2:0]       phase,
  input logic             pending_o,
  input logic             commit_o,
  input logic [CNT_W-1:0] rollback_cnt
);
  a_r2_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_req |=> !reconfig_req);

  a_r2_update_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (reconfig_req && slot_sel) |-> (pending_o || commit_o));

  a_r3_load_after_integrity: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 && $past(phase) != 3'd3) |-> $past(integ_valid && integ_ok));

  a_r5_run_from_done_or_health: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_en) |-> $past(cfg_done || (health_valid && health_ok)));

  a_r5_no_run_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (train_en && slot_sel) |-> !pending_o);

  a_r7_rollback_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rollback_cnt) |->
      (rollback_cnt == $past(rollback_cnt) + 1'b1) && !slot_sel && !pending_o && !commit_o);

  a_r8_recovery_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    service_mode |=> (service_mode && !reconfig_req));
endmodule

bind boot_image_selector bsel_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .integ_valid(integ_valid), .integ_ok(integ_ok),
  .cfg_done(cfg_done), .health_valid(health_valid), .health_ok(health_ok),
  .slot_sel(slot_sel), .reconfig_req(reconfig_req), .train_en(train_en),
  .service_mode(service_mode), .phase(phase), .pending_o(pending_o),
  .commit_o(commit_o), .rollback_cnt(rollback_cnt)
);

// File: tb/boot_image_selector_test.sv
module boot_image_selector_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO_W = 16;
  localparam int CNT_W = 8;
  localparam int TMO   = 5;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prereq_ok = 1'b0, meta_pending = 1'b0, meta_commit = 1'b0;
  logic [TMO_W-1:0] tmo_limit = TMO_W'(TMO);
  logic integ_valid = 1'b0, integ_ok = 1'b0, cfg_done = 1'b0;
  logic health_valid = 1'b0, health_ok = 1'b0, train_fail = 1'b0;
  logic slot_sel, reconfig_req, train_en, service_mode, pending_o, commit_o;
  logic [2:0] phase, rollback_why, stop_phase;
  logic [CNT_W-1:0] rollback_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_image_selector #(.MAX_TRIES(3), .TMO_W(TMO_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .prereq_ok(prereq_ok), .meta_pending(meta_pending),
    .meta_commit(meta_commit), .tmo_limit(tmo_limit), .integ_valid(integ_valid),
    .integ_ok(integ_ok), .cfg_done(cfg_done), .health_valid(health_valid),
    .health_ok(health_ok), .train_fail(train_fail), .slot_sel(slot_sel),
    .reconfig_req(reconfig_req), .train_en(train_en), .service_mode(service_mode),
    .phase(phase), .pending_o(pending_o), .commit_o(commit_o),
    .rollback_cnt(rollback_cnt), .rollback_why(rollback_why), .stop_phase(stop_phase)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // Monitor: every reconfigure request is compared against the queued slot.
  always @(negedge clk) begin
    if (rst_n && reconfig_req) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected reconfig got=%0d exp=none", slot_sel);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (slot_sel !== e) begin
          n_fail++;
          $display("FAIL R2 slot at reconfig got=%0d exp=%0d", slot_sel, e);
        end
      end
    end
  end

  task automatic wait_phase(input logic [2:0] p);
    while (phase !== p) @(negedge clk);
  endtask

  task automatic boot_start(input logic p, input logic c);
    @(negedge clk);
    rst_n = 1'b0; prereq_ok = 1'b0; meta_pending = p; meta_commit = c;
    integ_valid = 0; cfg_done = 0; health_valid = 0; train_fail = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 phase after reset", phase, 0);
    chk("R1 slot after reset", slot_sel, 0);
    chk("R1 outputs idle", {reconfig_req, train_en, service_mode}, 0);
    chk("R1 rollback state", {rollback_cnt, rollback_why, stop_phase}, 0);
    prereq_ok = 1'b1;
  endtask

  task automatic give_integ(input logic ok);
    wait_phase(3'd2);
    integ_valid = 1'b1; integ_ok = ok;
    @(negedge clk);
    integ_valid = 1'b0;
  endtask

  task automatic give_done();
    wait_phase(3'd3);
    cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
  endtask

  task automatic give_health(input logic ok);
    wait_phase(3'd4);
    health_valid = 1'b1; health_ok = ok;
    @(negedge clk);
    health_valid = 1'b0;
  endtask

  task automatic give_train_fail();
    wait_phase(3'd5);
    train_fail = 1'b1;
    @(negedge clk);
    train_fail = 1'b0;
  endtask

  task automatic let_expire(input string tag);
    int n;
    n = 0;
    wait_phase(3'd3);
    while (phase == 3'd3) begin n++; @(negedge clk); end
    chk(tag, n, TMO + 1);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // Golden boot, no flags.
    exp_q.push_back(1'b0);
    boot_start(0, 0);
    give_integ(1);
    give_done();
    chk("R5 golden goes straight to run", phase, 5);
    chk("R5 train_en in run", train_en, 1);

    // Pending update, health pass -> commit.
    exp_q.push_back(1'b1);
    boot_start(1, 0);
    give_integ(1);
    chk("R3 load after integrity pass", phase, 3);
    give_done();
    chk("R5 pending update enters health", phase, 4);
    chk("R5 no training in health", train_en, 0);
    give_health(1);
    chk("R5 run after health pass", phase, 5);
    chk("R5 commit set pending cleared", {commit_o, pending_o}, 2'b10);
    chk("R7 no rollback on success", rollback_cnt, 0);

    // Update integrity failure -> immediate rollback.
    exp_q.push_back(1'b1); exp_q.push_back(1'b0);
    boot_start(1, 0);
    give_integ(0);
    chk("R3 rollback reason integrity", rollback_why, 1);
    chk("R7 rollback count", rollback_cnt, 1);
    chk("R7 stop phase read", stop_phase, 2);
    chk("R7 flags cleared", {pending_o, commit_o}, 0);
    give_integ(1);
    give_done();
    chk("R7 golden runs after rollback", {phase, slot_sel}, {3'd5, 1'b0});

    // Update timeouts: two retries then rollback.
    exp_q.push_back(1'b1); exp_q.push_back(1'b1); exp_q.push_back(1'b1); exp_q.push_back(1'b0);
    boot_start(1, 0);
    give_integ(1);
    let_expire("R4 load window length");
    chk("R6 first timeout is no rollback", rollback_cnt, 0);
    chk("R6 pending kept after retry", pending_o, 1);
    chk("R7 stop phase load", stop_phase, 3);
    give_integ(1);
    let_expire("R4 second window");
    give_integ(1);
    let_expire("R4 third window");
    chk("R6 third timeout rolls back", rollback_cnt, 1);
    chk("R7 reason timeout", rollback_why, 2);
    chk("R7 golden selected", slot_sel, 0);

    // Health failures on pending update.
    exp_q.push_back(1'b1); exp_q.push_back(1'b1); exp_q.push_back(1'b1); exp_q.push_back(1'b0);
    boot_start(1, 0);
    for (int i = 0; i < 3; i++) begin
      give_integ(1);
      give_done();
      give_health(0);
      if (i == 1) chk("R6 two health fails no rollback", rollback_cnt, 0);
    end
    chk("R6 health rollback reason", rollback_why, 3);
    chk("R7 stop phase health", stop_phase, 4);
    chk("R7 pending cleared after health rollback", pending_o, 0);

    // Committed update, training failures.
    exp_q.push_back(1'b1); exp_q.push_back(1'b1); exp_q.push_back(1'b1); exp_q.push_back(1'b0);
    boot_start(0, 1);
    for (int i = 0; i < 3; i++) begin
      give_integ(1);
      give_done();
      if (i == 0) chk("R5 committed skips health", phase, 5);
      give_train_fail();
    end
    chk("R6 train rollback reason", rollback_why, 4);
    chk("R7 stop phase run", stop_phase, 5);
    chk("R7 commit cleared", commit_o, 0);
    chk("R7 count after train rollback", rollback_cnt, 1);

    // Golden timeout retries golden; done on the last cycle wins.
    exp_q.push_back(1'b0); exp_q.push_back(1'b0);
    boot_start(0, 0);
    give_integ(1);
    let_expire("R4 golden window length");
    chk("R9 golden timeout no rollback", {rollback_cnt, rollback_why}, 0);
    chk("R9 stop phase load", stop_phase, 3);
    give_integ(1);
    wait_phase(3'd3);
    repeat (TMO) @(negedge clk);
    cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
    chk("R4 done on last cycle wins", phase, 5);

    // Golden integrity failure -> recovery.
    exp_q.push_back(1'b0);
    boot_start(0, 0);
    give_integ(0);
    chk("R8 recovery phase", phase, 6);
    chk("R8 service mode", service_mode, 1);
    repeat (10) @(negedge clk);
    chk("R8 recovery held", {phase, service_mode, train_en}, {3'd6, 1'b1, 1'b0});
    chk("R8 golden failure no rollback count", rollback_cnt, 0);
    chk("R2 expected requests consumed", exp_q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule